// File: doc/BRIEF.md
# SPI Slave Register Access Port

This block is a serial slave that lets an external master read and write a bank of 16-bit registers over four wires. The register bank itself sits outside the block. The block reaches it through a plain synchronous port made of an address, write data, a one-cycle write strobe and read data. The serial clock and the chip select are not used as clocks. A faster system clock oversamples them through two-stage synchronisers, and all logic runs on that system clock.

Each chip-select assertion carries exactly one 32-bit command, sent most significant bit first. The command holds a 4-bit opcode, a 10-bit register address, 2 delimiter bits and a 16-bit data word. The clock phase is mode 0: the slave samples SDI on the rising SCLK edge and changes SDO after the falling edge.

During the first 16 bits, SDO returns an error field that reports whether the previous command was cut short. During the last 16 bits it returns the register contents for a read. Commands with a bad opcode and clocks beyond the 32nd are answered with an alternating 1010 pattern.

Top module: `spi_reg_port`

## Requirements
- R1: A command starts only when CS_n falls. SCLK and SDI activity while CS_n is high causes no register write and does not disturb the next command.
- R2: Frame bits arrive MSB first, in this order: opcode in bits 1-4, address in bits 5-14, delimiter in bits 15-16, data in bits 17-32. The value of the delimiter bits is ignored.
- R3: Opcode 4'b0001 is a write. After the 32nd rising SCLK edge, reg_we pulses high for exactly one system clock, with reg_addr set to the frame address and reg_wdata set to the frame data.
- R4: Opcode 4'b0010 is a read. SDO bits 17-32 carry the contents of the addressed register, MSB first, and no write takes place. reg_rdata must follow reg_addr within 2 system clocks.
- R5: SDO bits 1-16 form the error field. It is all zeros if the previous command had 32 or more rising SCLK edges, including the case where there was no previous command since reset. It is 0xAAAA if the previous command had fewer than 32 rising edges, including zero. Bit n (counted from 1) of 0xAAAA is 1 when n is odd.
- R6: A command with fewer than 32 rising SCLK edges never produces a write strobe.
- R7: An opcode other than 4'b0001 or 4'b0010 produces no write and no address update. From bit 5 until CS_n rises, SDO drives the 0xAAAA pattern: bit n is 1 when n is odd. Such a frame counts as complete for the next error field when it ran for 32 edges.
- R8: Rising SCLK edges after the 32nd in one assertion are ignored; the command uses only the first 32 bits. On SDO, bit n for n > 32 follows the same odd-is-one pattern.
- R9: After reset, SDO and reg_we are low. SDO is low whenever CS_n is high. The first SDO bit is valid after CS_n falls and before the first rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| reg_addr | output | 10 | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Register read data |

## Verification
The bench sends several kinds of commands.

- **Truncated commands.** It sends a write cut off after 20 edges and a command with no clock at all. A design that counts badly would either fire a write strobe or fail to show 0xAAAA in the next error field.
- **Error flag lifetime.** It follows a flagged command with a good one, to catch a sticky flag that is never cleared.
- **Bad opcodes.** Illegal opcodes show whether the pattern starts at bit 5 and whether the write is suppressed.
- **Long commands.** 40-clock commands with all-ones trailing data catch a receiver that keeps shifting past bit 32. Such a receiver would corrupt the written word.
- **Edge addresses and idle clocks.** Addresses 0 and 1023, plus SCLK toggling with the chip select high, expose wrong field slicing and commands that start without a select edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int OPC_W   = 4;
  localparam int DELIM_W = 2;

  localparam logic [OPC_W-1:0] OPC_WRITE = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_READ  = 4'b0010;

  typedef struct packed {
    logic wr;
    logic rd;
    logic bad;
  } cmd_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_edges.sv
module spi_edges (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic cs_s,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise
);
  logic sclk_d;
  logic cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int HDR_W   = OPC_W + ADDR_W + DELIM_W,
  localparam int FRAME_W = HDR_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sdi_s,
  output logic              active,
  output logic [CNT_W-1:0]  bits,
  output cmd_t              cmd,
  output logic              short_flag,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_OPC = CNT_W'(OPC_W - 1);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-2:0] sh;
  logic [FRAME_W-1:0] nxt;
  logic [OPC_W-1:0]   opc;

  assign nxt = {sh, sdi_s};
  assign opc = nxt[OPC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      bits       <= '0;
      sh         <= '0;
      cmd        <= '0;
      short_flag <= 1'b0;
      reg_addr   <= '0;
      reg_wdata  <= '0;
      reg_we     <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (cs_fall) begin
        active <= 1'b1;
        bits   <= '0;
        cmd    <= '0;
      end else if (cs_rise) begin
        active     <= 1'b0;
        short_flag <= (bits != FULL_CNT);
      end else if (active && sclk_rise && bits != FULL_CNT) begin
        sh   <= nxt[FRAME_W-2:0];
        bits <= bits + 1'b1;
        if (bits == LAST_OPC) begin
          cmd.wr  <= (opc == OPC_WRITE);
          cmd.rd  <= (opc == OPC_READ);
          cmd.bad <= (opc != OPC_WRITE) && (opc != OPC_READ);
        end
        if (bits == LAST_HDR && !cmd.bad) begin
          reg_addr <= nxt[DELIM_W +: ADDR_W];
        end
        if (bits == LAST_BIT && cmd.wr) begin
          reg_wdata <= nxt[DATA_W-1:0];
          reg_we    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  localparam int HDR_W   = OPC_W + ADDR_W + DELIM_W,
  localparam int FRAME_W = HDR_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              short_flag,
  input  cmd_t              cmd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sdo
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HDR_W - 1);

  logic              tact;
  logic [CNT_W-1:0]  tcnt;
  logic              par;
  logic [DATA_W-1:0] rd_sh;
  logic              past_end;
  logic              in_err;
  logic              at_data0;

  // tcnt counts falling edges seen; the bit driven next has index tcnt+1
  assign past_end = (tcnt >= LAST_BIT);
  assign in_err   = (tcnt < LAST_HDR);
  assign at_data0 = (tcnt == LAST_HDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      tact  <= 1'b0;
      tcnt  <= '0;
      par   <= 1'b0;
      rd_sh <= '0;
      sdo   <= 1'b0;
    end else if (cs_fall) begin
      tact <= 1'b1;
      tcnt <= '0;
      par  <= 1'b0;
      sdo  <= short_flag;
    end else if (cs_rise) begin
      tact <= 1'b0;
      sdo  <= 1'b0;
    end else if (tact && sclk_fall) begin
      par <= ~par;
      if (tcnt != FULL_CNT) tcnt <= tcnt + 1'b1;
      if (cmd.bad || past_end) begin
        sdo <= par;
      end else if (in_err) begin
        sdo <= short_flag & par;
      end else if (at_data0) begin
        sdo   <= cmd.rd & reg_rdata[DATA_W-1];
        rd_sh <= {reg_rdata[DATA_W-2:0], 1'b0};
      end else begin
        sdo   <= cmd.rd & rd_sh[DATA_W-1];
        rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_reg_port.sv
module spi_reg_port
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HDR_W   = OPC_W + ADDR_W + DELIM_W,
  localparam int FRAME_W = HDR_W + DATA_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic [2:0]       pins_s;
  logic             sclk_s, cs_s, sdi_s;
  logic             sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic             rx_active;
  logic [CNT_W-1:0] rx_bits;
  cmd_t             cmd;
  logic             short_flag;

  spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst), .d({sclk, cs_n, sdi}), .q(pins_s)
  );

  assign sclk_s = pins_s[2];
  assign cs_s   = pins_s[1];
  assign sdi_s  = pins_s[0];

  spi_edges u_edges (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .cs_s(cs_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  spi_rx_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sdi_s(sdi_s), .active(rx_active), .bits(rx_bits),
    .cmd(cmd), .short_flag(short_flag), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we)
  );

  spi_tx_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .short_flag(short_flag), .cmd(cmd),
    .reg_rdata(reg_rdata), .sdo(sdo)
  );
endmodule

// File: rtl/spi_reg_port_chk.sv
module spi_reg_port_chk #(
  parameter int ADDR_W  = 10,
  parameter int CNT_W   = 6,
  parameter int FRAME_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_s,
  input logic              sdo,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              rx_active,
  input logic [CNT_W-1:0]  rx_bits,
  input logic              cmd_rd,
  input logic              cmd_bad
);
  // write strobe lasts a single system clock
  assert_we_single_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // address held steady while the strobe is high
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $stable(reg_addr));

  // strobe only after a full count of rising edges
  assert_we_full_frame_R6: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> (rx_bits == CNT_W'(FRAME_W)));

  // no command in flight means no write
  assert_we_needs_frame_R1: assert property (@(posedge clk) disable iff (rst)
    !rx_active |-> !reg_we);

  // illegal opcode never writes
  assert_bad_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    cmd_bad |-> !reg_we);

  // read command never writes
  assert_read_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_rd |-> !reg_we);

  // output is low while the select is idle
  assert_sdo_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    (cs_s && $past(cs_s)) |-> !sdo);
endmodule

bind spi_reg_port spi_reg_port_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .sdo(sdo), .reg_we(reg_we),
  .reg_addr(reg_addr), .rx_active(rx_active), .rx_bits(rx_bits),
  .cmd_rd(cmd.rd), .cmd_bad(cmd.bad)
);

// File: tb/spi_reg_port_bench.sv
module spi_reg_port_bench;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [9:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        reg_we;
  logic [15:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic short_prev = 1'b0;
  logic done = 1'b0;

  typedef struct packed {
    logic [9:0]  a;
    logic [15:0] d;
  } wr_t;
  wr_t exp_q[$];

  logic [15:0] mem     [1024];
  logic [15:0] exp_mem [1024];

  always #10 clk = ~clk;

  spi_reg_port u_spi_reg_port (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata)
  );

  // register bank model with one-cycle read latency
  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    reg_rdata <= mem[reg_addr];
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as strobes appear
  always @(negedge clk) begin
    if (!rst && reg_we) begin
      wr_t e;
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R6 R7 R1 unexpected write actual=%h expected=none",
                 {reg_addr, reg_wdata});
      end else begin
        e = exp_q.pop_front();
        chk("R3 write strobe addr/data", 64'({reg_addr, reg_wdata}), 64'(e));
      end
    end
  end

  task automatic frame(input logic [3:0] op, input logic [9:0] a, input logic [1:0] dl,
                       input logic [15:0] d, input int nclk, input string tag);
    logic [31:0] w;
    logic [63:0] got;
    logic [63:0] exp;
    logic        bad;
    logic [15:0] rv;
    w   = {op, a, dl, d};
    got = '0;
    exp = '0;
    bad = !(op == 4'b0001 || op == 4'b0010);
    rv  = (op == 4'b0010) ? exp_mem[a] : 16'h0;
    for (int i = 0; i < nclk; i++) begin
      if (i >= 32 || (bad && i >= 4)) exp[i] = ~i[0];
      else if (i < 16)                exp[i] = short_prev & ~i[0];
      else if (op == 4'b0010)         exp[i] = rv[31-i];
      else                            exp[i] = 1'b0;
    end
    if (op == 4'b0001 && nclk >= 32) begin
      exp_q.push_back({a, d});
      exp_mem[a] = d;
    end
    @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 32) ? w[31-i] : 1'b1;
      repeat (H) @(negedge clk);
      got[i] = sdo;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * H) @(negedge clk);
    chk({tag, " SDO bits"}, got, exp);
    chk({tag, " pending writes"}, 64'(exp_q.size()), 64'd0);
    chk({tag, " R9 SDO idle low"}, 64'(sdo), 64'd0);
    short_prev = (nclk < 32);
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      sdi = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4 * H) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 reset sdo", 64'(sdo), 64'd0);
    chk("R9 reset reg_we", 64'(reg_we), 64'd0);

    frame(4'b0001, 10'd0,    2'b00, 16'hBEEF, 32, "R3 R2 write addr 0");
    frame(4'b0001, 10'd1023, 2'b11, 16'h1234, 32, "R3 R2 write addr 1023 delim ignored");
    frame(4'b0010, 10'd0,    2'b00, 16'hFFFF, 32, "R4 read addr 0");
    frame(4'b0010, 10'd1023, 2'b10, 16'h0000, 32, "R4 read addr 1023");
    frame(4'b0001, 10'd5,    2'b00, 16'h7777, 20, "R6 short write");
    frame(4'b0010, 10'd1023, 2'b00, 16'h0000, 32, "R5 error field after short");
    frame(4'b0010, 10'd0,    2'b00, 16'h0000, 32, "R5 error field cleared");
    frame(4'b0001, 10'd9,    2'b00, 16'h0000, 0,  "R5 R6 empty select");
    frame(4'b0001, 10'd6,    2'b00, 16'h0F0F, 32, "R5 R3 write after empty select");
    frame(4'b1111, 10'd7,    2'b00, 16'hDEAD, 32, "R7 opcode 1111");
    frame(4'b0011, 10'd6,    2'b01, 16'h5555, 32, "R7 opcode 0011");
    frame(4'b0010, 10'd6,    2'b00, 16'h0000, 32, "R7 next frame clean");
    frame(4'b0001, 10'd8,    2'b00, 16'hC3C3, 40, "R8 long write");
    frame(4'b0010, 10'd8,    2'b00, 16'h0000, 40, "R8 long read");
    idle_clocks(33);
    chk("R1 idle clocks no write", 64'(exp_q.size()), 64'd0);
    frame(4'b0010, 10'd8,    2'b00, 16'h0000, 32, "R1 read after idle clocks");
    frame(4'b0010, 10'd0,    2'b00, 16'h0000, 10, "R5 short read");
    frame(4'b0010, 10'd1023, 2'b00, 16'h0000, 32, "R5 R4 read after short read");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule